// File: doc/BRIEF.md
# Byte-Paced I2C Master Controller

This block is an I2C bus master driven through three byte-wide registers: a control register (clock division, interrupt enable, pending flag, acknowledge enable), a status register (mode, start/stop request, output enable, arbitration and acknowledge flags) and a data register that doubles as the bit shifter. Software loads the slave address into the data register and writes the status register with a start request. The block then issues START, shifts the address out MSB first and samples the acknowledge bit.

After every ninth bit the block parks the bus. It raises a pending flag, asserts the interrupt if enabled, and holds SCL low until software writes the pending flag as zero. In transmit mode each resume sends the data register contents. In receive mode each resume shifts a byte in, and the master answers it with ACK or NACK according to the acknowledge-enable bit written with that resume. A stop request written to the status register while the bus is parked turns the next resume into a STOP condition, and no pending flag follows it.

Both bus lines are open-drain: `scl_oe`/`sda_oe` high pulls the line low, and `scl_in`/`sda_in` return the wired level. The register interface is a plain single-cycle write strobe with parallel readback. It has no valid/ready handshake, because every byte is paced by the pending flag.

Top module: `i2cm_ctrl`

## Requirements
- R1: After reset, `ctrl_q`, `stat_q` and `data_q` read 0, both line enables are 0 and `irq` is 0.
- R2: A status write with bits 7, 5 and 4 all set, issued while idle, pulls SDA low with SCL released for one half period. It then sends the data register MSB first as the address byte, and status bit 5 (busy) reads 1 from that write until the bus is released.
- R3: One half period is (ctrl bit 6 ? DIV_B : DIV_A)/2 × (ctrl[3:0]+1) clocks. Pending rises 19 half periods after the start write, and 18 half periods after a resume write.
- R4: At the end of the ninth bit, control bit 4 (pending) is set, status bit 0 takes the sampled acknowledge level (1 = NACK), and SCL stays pulled low while pending. `irq` equals pending AND control bit 5.
- R5: A control write with bit 4 = 0 clears pending and resumes a parked transfer. A control write with bit 4 = 1 never sets pending.
- R6: With status bits [7:6] = 11 (transmit), each resumed byte sends the current data register value MSB first.
- R7: With status bits [7:6] = 10 (receive), each resumed byte shifts the bus into the data register MSB first. The master pulls SDA low in the ninth bit only if control bit 7 was 1 in the resume write, and later writes to bit 7 do not alter that byte's answer.
- R8: A status write with bit 5 = 0 while parked arms a STOP. The next resume then produces SDA low, then SCL released, then SDA released, one half period each. Busy clears 3 half periods after the resume write, and pending is not set.
- R9: If the master releases SDA in an address or transmit bit and samples it low, it sets status bit 3, releases both lines, clears busy and sets pending 3 half periods after the start. The next START clears status bit 3.
- R10: Data register writes take effect only while idle or parked. During a byte, the register holds the bits sampled from the bus.
- R11: A start request is ignored while busy or when status bit 4 is written 0.
- R12: The SCL high phase is timed only from the cycle in which `scl_in` reads high, so a slave that holds SCL low lengthens the bit by the excess hold time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| ctrl_q | output | 8 | Control readback {ack_en, clk_sel, irq_en, pending, prescale[3:0]} |
| stat_q | output | 8 | Status readback {mode[1:0], busy, out_en, arb_lost, 0, 0, last_ack} |
| data_q | output | 8 | Data / shift register readback |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA line level |

## Verification
The properties assume that `scl_in` and `sda_in` are already synchronous to `clk`, that each write strobe lasts a single cycle, and that the prescaler and clock-select fields are left alone while a byte is in flight. The stimulus meets these assumptions. Its slave model and bus monitor update only on the rising clock edge from sampled line levels. Registers are written from a task that holds the strobe for exactly one cycle. The prescaler is changed only while the bus is idle between sweep steps, and stop requests are issued only while a transfer is parked.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int PRESC_W = 4;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_LOW, ST_HIGH, ST_HOLD, ST_STOP1, ST_STOP2, ST_STOP3
  } eng_state_t;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick
  import i2cm_pkg::*;
#(
  parameter int DIV_A = 16,
  parameter int DIV_B = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               clk_sel,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);
  localparam int CW = $clog2((DIV_B / 2) * (1 << PRESC_W) + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] base;
  logic [CW-1:0] half;

  always_comb begin
    base = clk_sel ? CW'(DIV_B / 2) : CW'(DIV_A / 2);
    half = base * (CW'(presc) + CW'(1));
    tick = run && (cnt >= half - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start_go,
  input  logic       stop_arm,
  input  logic       pend_clr,
  input  logic       ack_en_w,
  input  logic       data_we,
  input  logic [7:0] wdata,
  input  logic       tx_mode,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       run,
  output logic       quiet,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [7:0] data_q,
  output logic       busy,
  output logic       pend,
  output logic       arb_lost,
  output logic       last_ack
);
  eng_state_t state;
  logic [3:0] bit_idx;
  logic       tx_byte, ack_lat, stop_pend, sda_q;
  logic [7:0] shreg, nd;

  function automatic logic drv(input logic [3:0] idx, input logic [7:0] d,
                               input logic txb, input logic ackl);
    if (idx == 4'd8) return txb ? 1'b0 : ackl;
    return txb ? ~d[7] : 1'b0;
  endfunction

  always_comb begin
    nd     = {shreg[6:0], sda_in};
    quiet  = (state == ST_IDLE) || (state == ST_HOLD);
    busy   = (state != ST_IDLE);
    scl_oe = (state == ST_LOW) || (state == ST_HOLD) || (state == ST_STOP1);
    sda_oe = sda_q;
    data_q = shreg;
    run    = (state == ST_START) || (state == ST_LOW) || (state == ST_STOP1) ||
             (state == ST_STOP2) || (state == ST_STOP3) ||
             ((state == ST_HIGH) && scl_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_idx   <= '0;
      tx_byte   <= 1'b1;
      ack_lat   <= 1'b0;
      stop_pend <= 1'b0;
      sda_q     <= 1'b0;
      shreg     <= '0;
      pend      <= 1'b0;
      arb_lost  <= 1'b0;
      last_ack  <= 1'b0;
    end else begin
      if (pend_clr) pend <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (data_we) shreg <= wdata;
          if (start_go) begin
            state     <= ST_START;
            sda_q     <= 1'b1;
            tx_byte   <= 1'b1;
            arb_lost  <= 1'b0;
            bit_idx   <= '0;
            stop_pend <= 1'b0;
          end
        end
        ST_START: if (tick) begin
          state <= ST_LOW;
          sda_q <= drv(4'd0, shreg, 1'b1, ack_lat);
        end
        ST_LOW: if (tick) state <= ST_HIGH;
        ST_HIGH: if (tick) begin
          if (bit_idx == 4'd8) begin
            last_ack <= sda_in;
            pend     <= 1'b1;
            state    <= ST_HOLD;
          end else if (tx_byte && !sda_q && !sda_in) begin
            arb_lost <= 1'b1;
            pend     <= 1'b1;
            sda_q    <= 1'b0;
            state    <= ST_IDLE;
          end else begin
            shreg   <= nd;
            bit_idx <= bit_idx + 4'd1;
            sda_q   <= drv(bit_idx + 4'd1, nd, tx_byte, ack_lat);
            state   <= ST_LOW;
          end
        end
        ST_HOLD: begin
          if (data_we)  shreg     <= wdata;
          if (stop_arm) stop_pend <= 1'b1;
          if (pend_clr) begin
            if (stop_pend) begin
              state <= ST_STOP1;
              sda_q <= 1'b1;
            end else begin
              state   <= ST_LOW;
              bit_idx <= '0;
              tx_byte <= tx_mode;
              ack_lat <= ack_en_w;
              sda_q   <= drv(4'd0, shreg, tx_mode, ack_en_w);
            end
          end
        end
        ST_STOP1: if (tick) state <= ST_STOP2;
        ST_STOP2: if (tick) begin
          state <= ST_STOP3;
          sda_q <= 1'b0;
        end
        ST_STOP3: if (tick) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int DIV_A = 16,
  parameter int DIV_B = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] ctrl_q,
  output logic [7:0] stat_q,
  output logic [7:0] data_q,
  output logic       irq,
  output logic       scl_oe,
  input  logic       scl_in,
  output logic       sda_oe,
  input  logic       sda_in
);
  logic [PRESC_W-1:0] presc;
  logic irq_en, clk_sel, ack_en, out_en;
  logic [1:0] mode;
  logic run, tick, quiet, busy, pend, arb_lost, last_ack;
  logic wr_ctrl, wr_stat, wr_data, start_go, stop_arm, pend_clr;
  logic unused_stat_bits;

  always_comb begin
    wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
    wr_stat  = reg_wr && (reg_sel == SEL_STAT);
    wr_data  = reg_wr && (reg_sel == SEL_DATA);
    start_go = wr_stat && reg_wdata[7] && reg_wdata[5] && reg_wdata[4];
    stop_arm = wr_stat && !reg_wdata[5];
    pend_clr = wr_ctrl && !reg_wdata[4];
    unused_stat_bits = ^reg_wdata[3:0];
    irq      = pend && irq_en;
    ctrl_q   = {ack_en, clk_sel, irq_en, pend, presc};
    stat_q   = {mode, busy, out_en, arb_lost, 2'b00, last_ack};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc   <= '0;
      irq_en  <= 1'b0;
      clk_sel <= 1'b0;
      ack_en  <= 1'b0;
      mode    <= 2'b00;
      out_en  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        presc   <= reg_wdata[PRESC_W-1:0];
        irq_en  <= reg_wdata[5];
        clk_sel <= reg_wdata[6];
        ack_en  <= reg_wdata[7];
      end
      if (wr_stat && quiet) begin
        mode   <= reg_wdata[7:6];
        out_en <= reg_wdata[4];
      end
    end
  end

  i2cm_tick #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .clk_sel(clk_sel), .presc(presc), .tick(tick)
  );

  i2cm_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .start_go(start_go), .stop_arm(stop_arm), .pend_clr(pend_clr),
    .ack_en_w(reg_wdata[7]), .data_we(wr_data), .wdata(reg_wdata),
    .tx_mode(mode[0]), .scl_in(scl_in), .sda_in(sda_in),
    .run(run), .quiet(quiet), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .data_q(data_q), .busy(busy), .pend(pend), .arb_lost(arb_lost),
    .last_ack(last_ack)
  );
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_req,
  input logic [7:0] ctrl_q,
  input logic [7:0] stat_q,
  input logic       scl_oe,
  input logic       sda_oe
);
  // R4
  hold_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[4] && stat_q[5]) |-> scl_oe);

  // R2
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[5]) |-> (sda_oe && !scl_oe));

  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !ctrl_q[4]);

  // R8
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stat_q[5]) && !stat_q[3]) |-> !ctrl_q[4]);

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_q[5] |-> (!scl_oe && !sda_oe));

  // R9
  arb_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[3]) |-> (!stat_q[5] && ctrl_q[4] && !scl_oe && !sda_oe));
endmodule

bind i2cm_ctrl i2cm_chk u_i2cm_chk (
  .clk(clk), .rst_n(rst_n),
  .clr_req(reg_wr && (reg_sel == 2'd0) && !reg_wdata[4]),
  .ctrl_q(ctrl_q), .stat_q(stat_q), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/test_i2cm_ctrl.sv
module test_i2cm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DA = 4;
  localparam int DB = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] ctrl_q, stat_q, data_q;
  logic irq, scl_oe, sda_oe;
  logic tb_scl_low = 1'b0;
  logic sl_drive = 1'b0;
  logic scl_bus, sda_bus;

  int checks = 0, fails = 0;
  int role = 0;
  logic slv_ack = 1'b1, slv_off = 1'b0;
  logic [7:0] slv_byte = 8'h00;
  logic scl_p = 1'b1, sda_p = 1'b1;
  int rcnt = 0, n_start = 0, n_stop = 0, n_bytes = 0;
  logic [7:0] sh = 8'h00, mon_byte = 8'h00;
  logic mon_ack = 1'b1;

  assign scl_bus = !(scl_oe || tb_scl_low);
  assign sda_bus = !(sda_oe || sl_drive);

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2cm_ctrl #(.DIV_A(DA), .DIV_B(DB)) i_i2cm_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .data_q(data_q), .irq(irq),
    .scl_oe(scl_oe), .scl_in(scl_bus), .sda_oe(sda_oe), .sda_in(sda_bus)
  );

  // bus monitor and slave model
  always @(posedge clk) begin
    scl_p <= scl_bus;
    sda_p <= sda_bus;
    if (scl_p && scl_bus && sda_p && !sda_bus) begin
      rcnt <= 0;
      n_start <= n_start + 1;
    end else if (scl_p && scl_bus && !sda_p && sda_bus) begin
      n_stop <= n_stop + 1;
    end
    if (!scl_p && scl_bus) begin
      if (rcnt < 8) sh <= {sh[6:0], sda_bus};
      else begin
        mon_byte <= sh;
        mon_ack  <= sda_bus;
        n_bytes  <= n_bytes + 1;
      end
      rcnt <= (rcnt >= 8) ? 0 : rcnt + 1;
    end
    if (slv_off) sl_drive <= 1'b0;
    else if (!scl_bus) begin
      case (role)
        1:       sl_drive <= (rcnt < 8) ? !slv_byte[7 - rcnt] : 1'b0;
        2:       sl_drive <= (rcnt < 8);
        default: sl_drive <= (rcnt == 8) && slv_ack;
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_pend(output int n);
    n = 0;
    while (!ctrl_q[4] && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (stat_q[5] && n < 20000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, st, sp;
    logic [7:0] ad, dd;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", ctrl_q, 0);
    chk("R1 stat", stat_q, 0);
    chk("R1 data", data_q, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 0);
    chk("R1 irq", irq, 0);

    // sweep over clock select and prescaler: transmit address + one byte + stop
    for (int cs = 0; cs < 2; cs++) begin
      for (int p = 0; p < 16; p++) begin
        int h;
        h = (cs != 0 ? DB / 2 : DA / 2) * (p + 1);
        ad = 8'(p * 17 + cs * 77 + 1);
        dd = ~ad ^ 8'(p);
        role = 0; slv_ack = 1'b1;
        wr(2'd0, {1'b1, 1'(cs), 1'b1, 1'b0, 4'(p)});
        wr(2'd2, ad);
        st = n_start;
        wr(2'd1, 8'hF0);
        chk("R2 busy", stat_q[5], 1);
        chk("R2 start lines", {sda_oe, scl_oe}, 2);
        wait_pend(n);
        chk("R3 addr time", n, 19 * h);
        chk("R2 addr byte", mon_byte, ad);
        chk("R2 start seen", n_start, st + 1);
        chk("R4 ack flag", stat_q[0], 0);
        chk("R4 irq", irq, 1);
        repeat (3 * h + 5) @(negedge clk);
        chk("R4 hold", {scl_oe, ctrl_q[4]}, 3);
        wr(2'd2, dd);
        wr(2'd0, {1'b1, 1'(cs), 1'b1, 1'b0, 4'(p)});
        wait_pend(n);
        chk("R3 byte time", n, 18 * h);
        chk("R6 tx byte", mon_byte, dd);
        sp = n_stop;
        wr(2'd1, 8'hD0);
        wr(2'd0, {1'b1, 1'(cs), 1'b1, 1'b0, 4'(p)});
        wait_idle(n);
        chk("R8 stop time", n, 3 * h);
        @(negedge clk);
        chk("R8 stop seen", n_stop, sp + 1);
        chk("R8 no pend", ctrl_q[4], 0);
      end
    end

    // receive mode, h = 2
    role = 0; slv_ack = 1'b1;
    wr(2'd0, 8'hA0);
    wr(2'd2, 8'hA1);
    wr(2'd1, 8'hB0);
    wait_pend(n);
    chk("R7 addr acked", stat_q[0], 0);
    role = 1; slv_byte = 8'h5C;
    wr(2'd0, 8'hA0);
    repeat (4) @(negedge clk);
    wr(2'd2, 8'hFF);   // R10 ignored while shifting
    wr(2'd0, 8'h20);   // R7 late ack-enable change
    wait_pend(n);
    chk("R7 rx data", data_q, 8'h5C);
    chk("R10 data write ignored", data_q, 8'h5C);
    chk("R7 master ack", mon_ack, 0);
    slv_byte = 8'h93;
    wr(2'd0, 8'h20);
    wait_pend(n);
    chk("R7 rx data2", data_q, 8'h93);
    chk("R7 master nack", mon_ack, 1);
    chk("R7 nack flag", stat_q[0], 1);
    role = 0;
    wr(2'd1, 8'h90);
    wr(2'd0, 8'h20);
    wait_idle(n);
    chk("R8 rx stop", n, 6);

    // address NACK, interrupt disabled, start while busy
    slv_ack = 1'b0;
    wr(2'd0, 8'h80);
    wr(2'd2, 8'h42);
    wr(2'd1, 8'hF0);
    wait_pend(n);
    chk("R4 nack flag", stat_q[0], 1);
    chk("R4 irq masked", irq, 0);
    st = n_start;
    wr(2'd1, 8'hF0);
    repeat (10) @(negedge clk);
    chk("R11 no restart", n_start, st);
    chk("R11 still parked", {scl_oe, ctrl_q[4]}, 3);
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'h80);
    wait_idle(n);
    slv_ack = 1'b1;

    // start with output disabled
    wr(2'd1, 8'hE0);
    repeat (10) @(negedge clk);
    chk("R11 out_en off", {stat_q[5], sda_oe}, 0);

    // software cannot set pending
    wr(2'd0, 8'h10);
    chk("R5 no sw set", ctrl_q, 0);

    // arbitration loss
    role = 2;
    wr(2'd2, 8'hA0);
    wr(2'd1, 8'hF0);
    wait_pend(n);
    chk("R9 arb time", n, 6);
    chk("R9 arb flag", stat_q[3], 1);
    chk("R9 arb idle", {stat_q[5], scl_oe, sda_oe}, 0);
    slv_off = 1'b1;
    wr(2'd0, 8'h00);
    chk("R5 pend clear", ctrl_q[4], 0);
    @(negedge clk);
    slv_off = 1'b0; role = 0;
    wr(2'd1, 8'hF0);
    chk("R9 flag cleared", stat_q[3], 0);
    wait_pend(n);

    // clock stretching on the resumed byte
    tb_scl_low = 1'b1;
    wr(2'd2, 8'h3C);
    wr(2'd0, 8'h00);
    repeat (9) @(negedge clk);
    tb_scl_low = 1'b0;
    wait_pend(n);
    chk("R12 stretch time", 9 + n, 17 * 2 + 9);
    chk("R12 stretch byte", mon_byte, 8'h3C);
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'h00);
    wait_idle(n);
    chk("R8 final idle", stat_q[5], 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule